// File: doc/BRIEF.md
# Challenge Prefix Replay Filter

This block guards a challenge–response exchange against replayed challenges. It keeps a short history of the leading bits of every challenge that the surrounding controller has already accepted after a successful ciphertext comparison. A new incoming challenge is presented as a prefix on the lookup port. One cycle later the block reports whether that prefix is already in the history. A hit means the controller must refuse the challenge.

The history is a small set of register slots. Each slot has its own valid bit, so an empty slot can never match. The controller pulses the insert port only after a challenge has passed verification. When every slot is occupied, the next insert replaces the oldest entry in first-in, first-out order. A clear input empties the whole history at record creation. A lookup never changes the stored contents.

Top module: `prefix_replay_filter`

## Requirements
- R1: After reset, every slot is empty. `hit_valid_o` and `hit_o` are 0, and any lookup, including the all-ones prefix, returns a miss.
- R2: `hit_valid_o` is 1 exactly in the cycle after a cycle with `lookup_valid_i` = 1, and is 0 otherwise.
- R3: A lookup whose prefix equals the prefix of any valid slot returns `hit_o` = 1 together with `hit_valid_o` = 1.
- R4: A lookup whose prefix differs from every valid slot in at least one bit returns `hit_o` = 0. `hit_o` is 0 whenever `hit_valid_o` is 0.
- R5: A lookup does not add its prefix to the history. Repeating a lookup of a missing prefix gives a miss again.
- R6: Inserts fill the slots in turn. With all DEPTH slots valid (DEPTH = 5 by default), the next insert evicts the earliest-inserted prefix that is still held, and keeps the other DEPTH-1 prefixes.
- R7: When a lookup and an insert occur in the same cycle, the lookup result reflects the contents before that insert. A later lookup of the inserted prefix hits.
- R8: `clear_i` empties every slot within one cycle. An insert in the same cycle as a clear is discarded. A lookup in the same cycle as a clear sees the contents before the clear.
- R9: Empty slots never match. Looking up the all-zero prefix misses unless the all-zero prefix was inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Empty the whole history |
| lookup_valid_i | input | 1 | Lookup request strobe |
| lookup_prefix_i | input | PFX_W (10) | Prefix to search for |
| insert_i | input | 1 | Store `insert_prefix_i` after a successful verification |
| insert_prefix_i | input | PFX_W (10) | Prefix to store |
| hit_valid_o | output | 1 | Lookup result is valid this cycle |
| hit_o | output | 1 | Prefix found in the history |

## Verification
The hardest situation to create is an eviction under a full history, because the oldest slot must be overwritten while every other slot stays intact. The stimulus fills all five slots with distinct prefixes and then inserts a sixth. Next it looks up all six prefixes. Then it inserts once more to confirm that the replacement point keeps advancing. Same-cycle collisions are forced by driving insert with lookup, and clear with insert or lookup, on one clock edge, using the same prefix.

// File: rtl/replay_pkg.sv
package replay_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_INSERT = 2'd1,
    OP_CLEAR  = 2'd2
  } slot_op_e;
endpackage

// File: rtl/replay_slot.sv
module replay_slot
  import replay_pkg::*;
#(
  parameter int unsigned PFX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  slot_op_e         op_i,
  input  logic             sel_i,
  input  logic [PFX_W-1:0] data_i,
  output logic             valid_o,
  output logic [PFX_W-1:0] prefix_o
);
  logic             valid_q;
  logic [PFX_W-1:0] prefix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      prefix_q <= '0;
    end else begin
      case (op_i)
        OP_CLEAR:  valid_q <= 1'b0;
        OP_INSERT: if (sel_i) begin
          valid_q  <= 1'b1;
          prefix_q <= data_i;
        end
        default: ;
      endcase
    end
  end

  assign valid_o  = valid_q;
  assign prefix_o = prefix_q;
endmodule

// File: rtl/replay_match.sv
module replay_match #(
  parameter int unsigned PFX_W = 10,
  parameter int unsigned DEPTH = 5
) (
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0][PFX_W-1:0] prefix_i,
  input  logic [PFX_W-1:0]            key_i,
  output logic                        match_o
);
  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    // invalid slots are masked so stale or zero contents never match
    assign eq[g] = valid_i[g] && (prefix_i[g] == key_i);
  end

  assign match_o = |eq;
endmodule

// File: rtl/replay_fifo_ptr.sv
module replay_fifo_ptr #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (clear_i)  ptr_q <= '0;
    else if (adv_i)    ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/prefix_replay_filter.sv
module prefix_replay_filter
  import replay_pkg::*;
#(
  parameter int unsigned PFX_W = 10,
  parameter int unsigned DEPTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             lookup_valid_i,
  input  logic [PFX_W-1:0] lookup_prefix_i,
  input  logic             insert_i,
  input  logic [PFX_W-1:0] insert_prefix_i,
  output logic             hit_valid_o,
  output logic             hit_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]            entry_valid;
  logic [DEPTH-1:0][PFX_W-1:0] entry_prefix;
  logic [PTR_W-1:0]            wr_ptr;
  slot_op_e                    op;
  logic                        match;
  logic                        hit_valid_q, hit_q;

  // clear wins over insert in the same cycle
  always_comb begin
    if (clear_i)       op = OP_CLEAR;
    else if (insert_i) op = OP_INSERT;
    else               op = OP_IDLE;
  end

  replay_fifo_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .adv_i   (insert_i && !clear_i),
    .ptr_o   (wr_ptr)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    replay_slot #(.PFX_W(PFX_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .op_i     (op),
      .sel_i    (wr_ptr == PTR_W'(g)),
      .data_i   (insert_prefix_i),
      .valid_o  (entry_valid[g]),
      .prefix_o (entry_prefix[g])
    );
  end

  // compares against pre-update contents, so same-cycle writes are not seen
  replay_match #(.PFX_W(PFX_W), .DEPTH(DEPTH)) u_match (
    .valid_i  (entry_valid),
    .prefix_i (entry_prefix),
    .key_i    (lookup_prefix_i),
    .match_o  (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_valid_q <= 1'b0;
      hit_q       <= 1'b0;
    end else begin
      hit_valid_q <= lookup_valid_i;
      hit_q       <= lookup_valid_i && match;
    end
  end

  assign hit_valid_o = hit_valid_q;
  assign hit_o       = hit_q;
endmodule

// File: rtl/replay_filter_checker.sv
module replay_filter_checker #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned PTR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             insert_i,
  input logic             lookup_valid_i,
  input logic             hit_valid_o,
  input logic             hit_o,
  input logic [DEPTH-1:0] entry_valid_i,
  input logic [PTR_W-1:0] wr_ptr_i
);
  a_r2_result_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> hit_valid_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !hit_valid_o);

  a_r4_hit_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_valid_o |-> !hit_o);

  a_r5_no_change_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!insert_i && !clear_i) |=> $stable(entry_valid_i));

  a_r6_one_per_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_i |=> $countones(entry_valid_i) <= $countones($past(entry_valid_i)) + 1);

  a_r6_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_ptr_i) < DEPTH);

  a_r8_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (entry_valid_i == '0));
endmodule

bind prefix_replay_filter replay_filter_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clear_i        (clear_i),
  .insert_i       (insert_i),
  .lookup_valid_i (lookup_valid_i),
  .hit_valid_o    (hit_valid_o),
  .hit_o          (hit_o),
  .entry_valid_i  (entry_valid),
  .wr_ptr_i       (wr_ptr)
);

// File: tb/prefix_replay_filter_test.sv
module prefix_replay_filter_test;
  localparam int PFX_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clear, lk_v, ins;
  logic [PFX_W-1:0] lk_p, ins_p;
  logic             hit_v, hit;
  int               n_chk = 0, n_err = 0;

  always #2ns clk = ~clk;

  prefix_replay_filter #(.PFX_W(PFX_W), .DEPTH(5)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .lookup_valid_i(lk_v), .lookup_prefix_i(lk_p),
    .insert_i(ins), .insert_prefix_i(ins_p),
    .hit_valid_o(hit_v), .hit_o(hit)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one-cycle lookup, result sampled at the following falling edge
  task automatic lookup(logic [PFX_W-1:0] p, logic exp, string req);
    @(negedge clk); lk_v = 1'b1; lk_p = p;
    @(negedge clk); lk_v = 1'b0;
    chk({req, " hit_valid"}, hit_v, 1'b1);
    chk({req, " hit"}, hit, exp);
  endtask

  task automatic insert(logic [PFX_W-1:0] p);
    @(negedge clk); ins = 1'b1; ins_p = p;
    @(negedge clk); ins = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 hit_valid after reset", hit_v, 1'b0);
    chk("R1 hit after reset", hit, 1'b0);
    lookup(10'h3FF, 1'b0, "R1 ones prefix");
    lookup(10'h000, 1'b0, "R9 zero prefix empty");
  endtask

  task automatic t_latency();
    lookup(10'h011, 1'b0, "R2 lookup");
    @(negedge clk);
    chk("R2 hit_valid drops", hit_v, 1'b0);
    chk("R4 hit low when not valid", hit, 1'b0);
  endtask

  task automatic t_no_write_on_lookup();
    lookup(10'h155, 1'b0, "R5 first lookup");
    lookup(10'h155, 1'b0, "R5 repeat lookup");
  endtask

  task automatic t_hit_miss();
    insert(10'h155);
    lookup(10'h155, 1'b1, "R3 single entry");
    insert(10'h0AA);
    lookup(10'h0AA, 1'b1, "R3 second entry");
    lookup(10'h155, 1'b1, "R3 first still held");
    lookup(10'h154, 1'b0, "R4 lsb differs");
    lookup(10'h355, 1'b0, "R4 msb differs");
    lookup(10'h000, 1'b0, "R9 zero with partial fill");
    insert(10'h000);
    lookup(10'h000, 1'b1, "R9 zero after insert");
  endtask

  task automatic t_fifo();
    do_clear();
    for (int i = 1; i <= 5; i++) insert(PFX_W'(10'h100 + i));
    for (int i = 1; i <= 5; i++) lookup(PFX_W'(10'h100 + i), 1'b1, "R6 full");
    insert(10'h106);
    lookup(10'h101, 1'b0, "R6 oldest evicted");
    for (int i = 2; i <= 6; i++) lookup(PFX_W'(10'h100 + i), 1'b1, "R6 kept");
    insert(10'h107);
    lookup(10'h102, 1'b0, "R6 next oldest evicted");
    lookup(10'h107, 1'b1, "R6 newest");
    lookup(10'h103, 1'b1, "R6 kept after second evict");
  endtask

  task automatic t_same_cycle();
    do_clear();
    @(negedge clk); lk_v = 1'b1; lk_p = 10'h2A5; ins = 1'b1; ins_p = 10'h2A5;
    @(negedge clk); lk_v = 1'b0; ins = 1'b0;
    chk("R7 concurrent hit_valid", hit_v, 1'b1);
    chk("R7 concurrent sees old", hit, 1'b0);
    lookup(10'h2A5, 1'b1, "R7 later lookup");
  endtask

  task automatic t_clear();
    // lookup concurrent with clear sees pre-clear contents
    @(negedge clk); lk_v = 1'b1; lk_p = 10'h2A5; clear = 1'b1;
    @(negedge clk); lk_v = 1'b0; clear = 1'b0;
    chk("R8 lookup with clear", hit, 1'b1);
    lookup(10'h2A5, 1'b0, "R8 emptied");
    @(negedge clk); clear = 1'b1; ins = 1'b1; ins_p = 10'h033;
    @(negedge clk); clear = 1'b0; ins = 1'b0;
    lookup(10'h033, 1'b0, "R8 insert during clear dropped");
    insert(10'h044);
    lookup(10'h044, 1'b1, "R8 insert after clear");
  endtask

  initial begin
    #100us;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    clear = 1'b0; lk_v = 1'b0; ins = 1'b0; lk_p = '0; ins_p = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_no_write_on_lookup();
    t_hit_miss();
    t_fifo();
    t_same_cycle();
    t_clear();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule